// File: doc/BRIEF.md
# Low-Toggle Pseudorandom Test Vector Source

This block feeds primary inputs of a circuit under self-test with pseudorandom vectors while cutting how many input bits switch from one clock to the next. A 12-bit maximal-length linear feedback shift register supplies the random endpoints. Three stepping vectors are placed between each pair of consecutive register states. Each stepping vector moves one more 3-bit slice of the word from the old state toward the new one. Any single clock therefore flips at most three bits, where a plain register flips about six.

A 2-bit phase counter walks the Gray sequence 00, 01, 11, 10. The register state is held for the whole walk. It advances only on the wrap from 10 back to 00, so the output presents a true register state once every four enabled cycles. The `isRandom` flag marks that cycle. A seed port with a load strobe restarts the sequence from a chosen state. An enable input pauses everything.

Top module: `lpgen_top`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active high), the state is set to the default seed 12'hACE and the phase to 00. After that edge `vecOut` equals 12'hACE and `isRandom` is 1.
- R2: `seedLoad` high at an edge loads `seedIn` as the state and sets the phase to 00, whatever the value of `enable`. The next output is that seed, with `isRandom` at 1.
- R3: A load of the all-zero seed stores 12'h001 instead.
- R4: Register advance: the next state S' = {S[10:0], S[11]^S[5]^S[3]^S[0]}, which is the polynomial x^12+x^6+x^4+x+1. Starting from any non-zero seed, the state visits all 4095 non-zero values and then returns to the seed. It never reaches zero.
- R5: With `enable` held high, the phase follows 00→01→11→10→00. `isRandom` is 1 exactly in phase 00, which is one cycle in every four. The register advances only on the 10→00 step.
- R6: Let D = S ^ S'. In the k-th phase of the sequence (k = 1 for 01, 2 for 11, 3 for 10), `vecOut` = S ^ (D & mask), where the mask keeps bits [3k-1:0]. In phase 00, `vecOut` = S.
- R7: Between two consecutive outputs without a load between them, the changed bits all lie in a single group of bits [3g+2:3g], for g = 0..3.
- R8: `enable` low with no load freezes the phase and the state, so `vecOut` and `isRandom` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advances the phase (and, on wrap, the register) when high |
| seedLoad | input | 1 | Load strobe for `seedIn` |
| seedIn | input | 12 | Seed value; zero is replaced by 12'h001 |
| vecOut | output | 12 | Test vector toward the circuit under test |
| isRandom | output | 1 | High when `vecOut` is a true register state (phase 00) |

## Verification
The main sweep starts from the reset seed and runs the full 4095-state period with enable high. On every cycle it compares each output with an arithmetic model of the polynomial and the slice masks. This shows that the period is maximal, that no state repeats and that zero never appears. Short enable-low pauses are spread through the sweep; they show freezing apart from stepping. Loads of a non-zero seed in mid-phase, under enable low and of zero show restart priority and zero substitution. Loads of the all-ones seed and of a one-hot seed exercise the slice masks at their extremes.

// File: rtl/lpgen_pkg.sv
package lpgen_pkg;

  // Gray-ordered phase of the stepping walk
  typedef enum logic [1:0] {
    PH_RAND = 2'b00,
    PH_ONE  = 2'b01,
    PH_TWO  = 2'b11,
    PH_THR  = 2'b10
  } lpgen_phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadSeed;
    logic stepLfsr;
  } lpgen_strobe_t;

  // Position of a phase in the walk (0..3)
  function automatic logic [1:0] phaseIndex(input lpgen_phase_t ph);
    return {ph[1], ph[1] ^ ph[0]};
  endfunction

endpackage

// File: rtl/lpgen_ctrl.sv
module lpgen_ctrl
  import lpgen_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          seedLoad,
  output lpgen_phase_t  phase,
  output lpgen_strobe_t strobe
);

  lpgen_phase_t phaseNext;

  always_comb begin
    unique case (phase)
      PH_RAND: phaseNext = PH_ONE;
      PH_ONE:  phaseNext = PH_TWO;
      PH_TWO:  phaseNext = PH_THR;
      default: phaseNext = PH_RAND;
    endcase
  end

  always_comb begin
    strobe.loadSeed = seedLoad;
    strobe.stepLfsr = enable && !seedLoad && (phase == PH_THR);
  end

  always_ff @(posedge clk) begin
    if (rst || seedLoad) begin
      phase <= PH_RAND;
    end else if (enable) begin
      phase <= phaseNext;
    end
  end

endmodule

// File: rtl/lpgen_datapath.sv
module lpgen_datapath
  import lpgen_pkg::*;
#(
  parameter int          WIDTH = 12,
  parameter int          GROUP = 3,
  parameter logic [WIDTH-1:0] TAPS = 12'h829,
  parameter logic [WIDTH-1:0] SEED = 12'hACE
) (
  input  logic             clk,
  input  logic             rst,
  input  lpgen_strobe_t    strobe,
  input  lpgen_phase_t     phase,
  input  logic [WIDTH-1:0] seedIn,
  output logic [WIDTH-1:0] vecOut
);

  localparam int NUM_GROUPS = WIDTH / GROUP;
  localparam logic [WIDTH-1:0] ONE_SEED = WIDTH'(1);

  logic [WIDTH-1:0] lfsrState;
  logic [WIDTH-1:0] lfsrNext;
  logic [WIDTH-1:0] stepDiff;
  logic [WIDTH-1:0] sliceMask;
  logic [WIDTH-1:0] loadValue;
  logic [1:0]       phIdx;
  logic             feedback;

  assign feedback  = ^(lfsrState & TAPS);
  assign lfsrNext  = {lfsrState[WIDTH-2:0], feedback};
  assign stepDiff  = lfsrState ^ lfsrNext;
  assign loadValue = (seedIn == '0) ? ONE_SEED : seedIn;
  assign phIdx     = phaseIndex(phase);

  // Slice g joins the mask once the walk has passed it
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_mask
    assign sliceMask[g*GROUP +: GROUP] = {GROUP{(int'(phIdx) > g)}};
  end

  assign vecOut = lfsrState ^ (stepDiff & sliceMask);

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsrState <= SEED;
    end else if (strobe.loadSeed) begin
      lfsrState <= loadValue;
    end else if (strobe.stepLfsr) begin
      lfsrState <= lfsrNext;
    end
  end

endmodule

// File: rtl/lpgen_top.sv
module lpgen_top
  import lpgen_pkg::*;
#(
  parameter int          WIDTH = 12,
  parameter int          GROUP = 3,
  parameter logic [WIDTH-1:0] TAPS = 12'h829,
  parameter logic [WIDTH-1:0] SEED = 12'hACE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             seedLoad,
  input  logic [WIDTH-1:0] seedIn,
  output logic [WIDTH-1:0] vecOut,
  output logic             isRandom
);

  lpgen_phase_t  phase;
  lpgen_strobe_t strobe;

  lpgen_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .seedLoad (seedLoad),
    .phase    (phase),
    .strobe   (strobe)
  );

  lpgen_datapath #(
    .WIDTH (WIDTH),
    .GROUP (GROUP),
    .TAPS  (TAPS),
    .SEED  (SEED)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .phase  (phase),
    .seedIn (seedIn),
    .vecOut (vecOut)
  );

  assign isRandom = (phase == PH_RAND);

endmodule

// File: rtl/lpgen_checker.sv
module lpgen_checker #(
  parameter int WIDTH = 12,
  parameter int GROUP = 3,
  parameter logic [WIDTH-1:0] SEED = 12'hACE
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             seedLoad,
  input logic [WIDTH-1:0] seedIn,
  input logic [WIDTH-1:0] vecOut,
  input logic             isRandom
);

  localparam int NUM_GROUPS = WIDTH / GROUP;

  function automatic int groupsHit(input logic [WIDTH-1:0] d);
    int n = 0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (d[g*GROUP +: GROUP] != '0) n++;
    end
    return n;
  endfunction

  // R1: reset restores the default seed in phase 00
  assert_reset_seed_R1: assert property (@(posedge clk)
    rst |=> (vecOut == SEED) && isRandom);

  // R2: a load restarts at the seed in phase 00
  assert_load_restart_R2: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && seedIn != '0) |=> (vecOut == $past(seedIn)) && isRandom);

  // R3: zero seed is substituted
  assert_zero_seed_R3: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && seedIn == '0) |=> (vecOut == WIDTH'(1)) && isRandom);

  // R4: a true register state is never zero
  assert_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    isRandom |-> (vecOut != '0));

  // R5: after a random vector, an enabled step leaves phase 00
  assert_phase_leave_R5: assert property (@(posedge clk) disable iff (rst)
    (isRandom && enable && !seedLoad) |=> !isRandom);

  // R7: consecutive outputs differ within one bit slice
  assert_one_slice_R7: assert property (@(posedge clk) disable iff (rst)
    !seedLoad |=> (groupsHit(vecOut ^ $past(vecOut)) <= 1));

  // R8: enable low freezes the outputs
  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (!enable && !seedLoad) |=> $stable(vecOut) && $stable(isRandom));

endmodule

bind lpgen_top lpgen_checker #(
  .WIDTH (WIDTH),
  .GROUP (GROUP),
  .SEED  (SEED)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .seedLoad (seedLoad),
  .seedIn   (seedIn),
  .vecOut   (vecOut),
  .isRandom (isRandom)
);

// File: tb/tb_lpgen_top.sv
module tb_lpgen_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        seedLoad = 1'b0;
  logic [11:0] seedIn = '0;
  logic [11:0] vecOut;
  logic        isRandom;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  logic [11:0] mState;
  int          mPhase;
  logic [11:0] prevOut;

  always #4 clk = ~clk;

  lpgen_top dut (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .seedLoad (seedLoad),
    .seedIn   (seedIn),
    .vecOut   (vecOut),
    .isRandom (isRandom)
  );

  function automatic logic [11:0] advance(input logic [11:0] s);
    return {s[10:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
  endfunction

  function automatic logic [11:0] expectOut(input logic [11:0] s, input int k);
    logic [11:0] msk = 12'((1 << (3 * k)) - 1);
    return s ^ ((s ^ advance(s)) & msk);
  endfunction

  function automatic int slicesHit(input logic [11:0] d);
    int n = 0;
    for (int g = 0; g < 4; g++) if (d[g*3 +: 3] != 3'b000) n++;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock of stimulus, model update, then sample after the edge
  task automatic drive(input logic en, input logic ld, input logic [11:0] sd);
    @(negedge clk);
    enable = en; seedLoad = ld; seedIn = sd;
    prevOut = vecOut;
    @(posedge clk);
    #1;
    if (ld) begin
      mState = (sd == 12'h000) ? 12'h001 : sd;
      mPhase = 0;
    end else if (en) begin
      if (mPhase == 3) begin
        mState = advance(mState);
        mPhase = 0;
      end else begin
        mPhase++;
      end
    end
  endtask

  task automatic checkOut(input string req);
    check(vecOut == expectOut(mState, mPhase), req, vecOut, expectOut(mState, mPhase));
    check(isRandom == (mPhase == 0), "R5 flag", isRandom, (mPhase == 0));
  endtask

  task automatic walkOnce(input string req);
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 1'b0, 12'h000);
      checkOut(req);
      check(slicesHit(vecOut ^ prevOut) <= 1, "R7 walk", vecOut ^ prevOut, 0);
    end
  endtask

  initial begin
    bit visited [4096];
    int distinct = 0;
    bit sawZero = 1'b0;

    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mState = 12'hACE; mPhase = 0;
    #1;
    check(vecOut == 12'hACE, "R1 reset vector", vecOut, 12'hACE);
    check(isRandom == 1'b1, "R1 reset flag", isRandom, 1);

    // full period sweep with periodic pauses
    for (int n = 0; n < 4095; n++) begin
      if (!visited[mState]) distinct++;
      visited[mState] = 1'b1;
      if (mState == 12'h000) sawZero = 1'b1;
      for (int p = 0; p < 4; p++) begin
        drive(1'b1, 1'b0, 12'h000);
        checkOut("R6 sweep");
        check(slicesHit(vecOut ^ prevOut) <= 1, "R7 sweep", vecOut ^ prevOut, 0);
        if ((n % 97) == 5 && p == 1) begin
          drive(1'b0, 1'b0, 12'h000);
          check(vecOut == prevOut, "R8 pause vector", vecOut, prevOut);
          checkOut("R8 pause model");
        end
      end
    end
    check(distinct == 4095, "R4 distinct states", distinct, 4095);
    check(!sawZero, "R4 zero state", sawZero, 0);
    check(mState == 12'hACE && vecOut == 12'hACE && isRandom, "R4 period return", vecOut, 12'hACE);

    // load in mid-walk with enable high
    drive(1'b1, 1'b0, 12'h000);
    drive(1'b1, 1'b0, 12'h000);
    drive(1'b1, 1'b1, 12'h5A3);
    check(vecOut == 12'h5A3 && isRandom, "R2 load mid-walk", vecOut, 12'h5A3);
    walkOnce("R6 after load");

    // load with enable low
    drive(1'b1, 1'b0, 12'h000);
    drive(1'b0, 1'b1, 12'h3C7);
    check(vecOut == 12'h3C7 && isRandom, "R2 load enable low", vecOut, 12'h3C7);
    drive(1'b0, 1'b0, 12'h000);
    check(vecOut == 12'h3C7 && isRandom, "R8 hold after load", vecOut, 12'h3C7);
    walkOnce("R5 walk after hold");

    // zero seed
    drive(1'b1, 1'b1, 12'h000);
    check(vecOut == 12'h001 && isRandom, "R3 zero seed", vecOut, 12'h001);
    walkOnce("R3 walk from one");

    // mask extremes
    drive(1'b1, 1'b1, 12'hFFF);
    check(vecOut == 12'hFFF, "R2 load ones", vecOut, 12'hFFF);
    walkOnce("R6 all ones");
    drive(1'b1, 1'b1, 12'h800);
    walkOnce("R6 top bit");

    // reset in mid-walk
    drive(1'b1, 1'b0, 12'h000);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check(vecOut == 12'hACE && isRandom, "R1 reset mid-walk", vecOut, 12'hACE);
    @(negedge clk); rst = 1'b0;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule